// File: doc/BRIEF.md
# Dual-Rail Phase-Checked LUT Cell

This block is a small programmable logic cell. Each logical input bit arrives on two wires: a value rail and a repeat rail. The value rail carries the data bit. The exclusive-OR of the two rails gives the token phase. The cell fires only when a new token is present on every input at once. That is the case when all input phases agree with each other and differ from the phase of the output. When the cell fires, it looks up a programmable truth table, indexed by the value rails, and issues a new output token.

The output keeps only its value bit in a register. A separate phase bit holds the token phase, and it changes only when a token is accepted. The output repeat rail is computed from those two bits. Each accepted token therefore flips exactly one output wire. A one-cycle completion pulse marks every accepted token. Data moves bit-serially, one token per evaluation. The cell is modelled with ordinary synchronous sampling on a clock.

Top module: `ledr_lut_cell`

## Requirements
- R1: While rst_ni is low, and on the first edge after it rises, out_v_o, out_r_o and done_o are 0. This gives an output phase of 0.
- R2: The phase of input pair i is in_v_i[i] XOR in_r_i[i]. A token is accepted at a clock edge only when all N_IN input phases are equal and differ from the output phase out_v_o XOR out_r_o.
- R3: After an accepting edge, out_v_o equals cfg_i[idx], where idx is the vector in_v_i sampled at that edge (pair 0 is the LSB of idx).
- R4: After an accepting edge, the output phase has toggled, and exactly one of out_v_o and out_r_o has changed.
- R5: out_r_o always equals out_v_o XOR the held phase bit. The held phase bit changes only on an accepting edge.
- R6: If the input phases disagree with each other, the outputs hold and done_o is 0 in the next cycle.
- R7: If all input phases equal the current output phase (no new token), the outputs hold and done_o is 0.
- R8: done_o is 1 for exactly the cycle after each accepting edge and 0 otherwise. The outputs change only when done_o is 1.
- R9: A change of cfg_i without an accepted token has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_v_i | input | N_IN | Value rails of the input pairs |
| in_r_i | input | N_IN | Repeat rails of the input pairs |
| cfg_i | input | 2**N_IN | Truth table, entry idx gives the output for data idx |
| out_v_o | output | 1 | Output value rail |
| out_r_o | output | 1 | Output repeat rail |
| done_o | output | 1 | One-cycle pulse per accepted token |

## Verification
The assertions assume one thing about the environment: once the cell has accepted a token, its producers do not send a fresh one until they see the new output phase. They also assume the rails are stable around each sampling edge. The stimulus honours this by changing inputs only at the falling clock edge. It presents each new token as a complete set of rails, with every phase set to the inverse of the model's output phase. The bench also injects mismatched-phase and stale-phase inputs, and changes cfg_i while the cell is idle. These cases test that nothing moves when no token should be accepted.

// File: rtl/ledr_pkg.sv
package ledr_pkg;
  localparam int unsigned DEF_N_IN = 4;

  function automatic logic pair_phase(input logic v, input logic r);
    return v ^ r;
  endfunction
endpackage

// File: rtl/ledr_phase_detect.sv
module ledr_phase_detect #(
  parameter int unsigned N_IN = ledr_pkg::DEF_N_IN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_v_i,
  input  logic [N_IN-1:0] in_r_i,
  input  logic            out_ph_i,
  output logic            valid_o
);
  logic [N_IN-1:0] ph;
  logic            all_one, all_zero;

  for (genvar i = 0; i < N_IN; i++) begin : g_ph
    assign ph[i] = ledr_pkg::pair_phase(in_v_i[i], in_r_i[i]);
  end

  assign all_one  = &ph;
  assign all_zero = ~|ph;
  assign valid_o  = out_ph_i ? all_zero : all_one;

  // R6
  phase_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_one && !all_zero) |-> !valid_o);
  // R7
  stale_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((all_one && out_ph_i) || (all_zero && !out_ph_i)) |-> !valid_o);
endmodule

// File: rtl/ledr_lut_tree.sv
module ledr_lut_tree #(
  parameter int unsigned N_IN = ledr_pkg::DEF_N_IN,
  localparam int unsigned LUT_W = 2 ** N_IN
) (
  input  logic [N_IN-1:0]  sel_i,
  input  logic [LUT_W-1:0] cfg_i,
  output logic             bit_o
);
  for (genvar l = 0; l <= N_IN; l++) begin : g_lvl
    localparam int unsigned W = 2 ** (N_IN - l);
    logic [W-1:0] node;
    if (l == 0) begin : g_leaf
      assign node = cfg_i;
    end else begin : g_mux
      for (genvar j = 0; j < W; j++) begin : g_n
        assign node[j] = sel_i[l-1] ? g_lvl[l-1].node[2*j+1] : g_lvl[l-1].node[2*j];
      end
    end
  end

  assign bit_o = g_lvl[N_IN].node[0];
endmodule

// File: rtl/ledr_out_stage.sv
module ledr_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic bit_i,
  output logic out_v_o,
  output logic out_r_o,
  output logic ph_o,
  output logic done_o
);
  logic v_q, ph_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept_i;
      if (accept_i) begin
        v_q  <= bit_i;
        ph_q <= ~ph_q;
      end
    end
  end

  // repeat rail rebuilt from value and phase
  assign out_v_o = v_q;
  assign out_r_o = v_q ^ ph_q;
  assign ph_o    = ph_q;
  assign done_o  = done_q;

  // R4
  one_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((out_v_o != $past(out_v_o)) != (out_r_o != $past(out_r_o))));
  // R5
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(ph_o));
endmodule

// File: rtl/ledr_lut_cell.sv
module ledr_lut_cell #(
  parameter int unsigned N_IN = ledr_pkg::DEF_N_IN,
  localparam int unsigned LUT_W = 2 ** N_IN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_v_i,
  input  logic [N_IN-1:0]  in_r_i,
  input  logic [LUT_W-1:0] cfg_i,
  output logic             out_v_o,
  output logic             out_r_o,
  output logic             done_o
);
  logic valid, lut_bit, ph;

  ledr_phase_detect #(.N_IN(N_IN)) u_det (
    .clk_i, .rst_ni, .in_v_i, .in_r_i, .out_ph_i(ph), .valid_o(valid)
  );

  ledr_lut_tree #(.N_IN(N_IN)) u_lut (
    .sel_i(in_v_i), .cfg_i, .bit_o(lut_bit)
  );

  ledr_out_stage u_out (
    .clk_i, .rst_ni, .accept_i(valid), .bit_i(lut_bit),
    .out_v_o, .out_r_o, .ph_o(ph), .done_o
  );

  // R2
  accept_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |=> done_o);
  // R3
  lut_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_v_o == $past(cfg_i[in_v_i])));
  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(out_v_o) && $stable(out_r_o)));
  // R5
  rail_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_v_o ^ out_r_o) == ph);
endmodule

// File: tb/sim_ledr_lut_cell.sv
module sim_ledr_lut_cell;
  localparam int N_IN = 4;
  localparam int LUT_W = 2 ** N_IN;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_IN-1:0] in_v = '0, in_r = '0;
  logic [LUT_W-1:0] cfg = '0;
  logic out_v, out_r, done;

  int errors = 0, checks = 0;
  logic exp_v = 1'b0, exp_ph = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledr_lut_cell #(.N_IN(N_IN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_v_i(in_v), .in_r_i(in_r), .cfg_i(cfg),
    .out_v_o(out_v), .out_r_o(out_r), .done_o(done)
  );

  function automatic logic [N_IN-1:0] rails_for(input logic [N_IN-1:0] d, input logic ph);
    return d ^ {N_IN{ph}};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {v,r,done} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // new token: all phases = ~exp_ph
  task automatic send_token(input logic [N_IN-1:0] d, input string req);
    in_v = d;
    in_r = rails_for(d, ~exp_ph);
    step();
    exp_v  = cfg[d];
    exp_ph = ~exp_ph;
    check(req, {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b1});
    step();
    check("R8", {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b0});
  endtask

  initial begin
    void'($urandom(32'h1ed5));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1", {out_v, out_r, done}, 3'b000);
    rst_ni = 1'b1;
    step();
    check("R1", {out_v, out_r, done}, 3'b000);

    // directed: inputs still in output phase 0 -> nothing
    cfg = 16'hFFFF;
    step();
    check("R7", {out_v, out_r, done}, 3'b000);

    cfg = 16'h8000;
    send_token(4'hF, "R3");
    send_token(4'h0, "R4");
    cfg = 16'h0001;
    send_token(4'h0, "R3");

    // mismatched phases
    in_v = 4'h0;
    in_r = 4'b0101 ^ rails_for(4'h0, exp_ph);
    step();
    check("R6", {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b0});

    // cfg change with no token
    cfg = ~cfg;
    in_r = rails_for(in_v, exp_ph);
    step();
    check("R9", {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b0});

    for (int n = 0; n < 300; n++) begin
      int kind = $urandom_range(0, 9);
      if (kind < 2) cfg = LUT_W'($urandom);
      if (kind < 7) begin
        send_token(N_IN'($urandom), "R2");
      end else if (kind < 9) begin
        logic [N_IN-1:0] d = N_IN'($urandom);
        logic [N_IN-1:0] m = N_IN'($urandom_range(1, 2**N_IN - 2));
        in_v = d;
        in_r = rails_for(d, ~exp_ph) ^ m;
        step();
        check("R6", {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b0});
      end else begin
        logic [N_IN-1:0] d = N_IN'($urandom);
        in_v = d;
        in_r = rails_for(d, exp_ph);
        cfg = LUT_W'($urandom);
        step();
        check("R9", {out_v, out_r, done}, {exp_v, exp_v ^ exp_ph, 1'b0});
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule